// File: doc/BRIEF.md
# Configurable Circular Self-Test Path Register

This block is an autonomous built-in self-test register that stimulates a circuit under test and compacts its responses in the same set of flip-flops. It has STAGES = IN_W + OUT_W - 1 stages. The upper stages drive the IN_W inputs of the circuit under test through an input connection network. The OUT_W circuit responses are folded into the lowest stages through an output connection network. Because the circuit closes part of the feedback loop, the register walks a non-linear state sequence.

A static configuration selects the behaviour. It picks, per stage, whether the stage shifts (D behaviour) or toggles (T behaviour). It can enable a wrap-around from the last stage into stage 0, a top parity feedback into stage 0 with a tap vector, and a bottom feedback of the same feedback value into the stages chosen by a second tap vector. It also picks the modes of the two connection matrices. Software seeds the register, starts a run of a programmed number of clocks, and reads the final register contents as the test signature once done is raised. The configuration is captured at start, so it has to be valid only at that moment. Invalid matrix settings are flagged, and a start request is refused while they are present. Parameters need IN_W + OUT_W >= 3.

Top module: `loop_bist_reg`

## Requirements
- R1: While reset is low, and in the first cycle after it, signature, busy and done are 0. The captured configuration returns to all zero.
- R2: A seedLoad pulse while not busy makes signature equal seedValue after the next clock edge, and clears done. A seedLoad pulse while busy has no effect on the sequence.
- R3: In each run clock, stage i (i >= 1) loads stage i-1. A stage whose tTypeMask bit is 1 also XORs in its own present value. Stage 0 always XORs in serialIn.
- R4: With wrapEn = 1, stage 0 also XORs in the feedback value. Without topEn, the feedback value is the last stage.
- R5: With topEn = 1, the feedback value is the parity of the register ANDed with topTaps, with topTaps bit STAGES-1 forced to 1, and stage 0 XORs in that value.
- R6: With botEn = 1, stage 0 and every stage i >= 1 whose botTaps bit i is 1 XOR in the feedback value. When topEn is also 1, this gives the derived cross terms botTaps[i] AND topTaps[j].
- R7: Only stages 0..OUT_W-1 receive response bits. With omMode 0, stage k takes cutResp[k]. With omMode 1 (permutation) or 2 (XOR), stage k takes the parity of cutResp ANDed with omMatrix bits k*OUT_W .. k*OUT_W+OUT_W-1.
- R8: cutDrive[r] depends only on the register state and the captured configuration. imMode 0 gives stage OUT_W-1+r. Modes 1 (permutation) and 2 (XOR) give the parity of stages selected by imMatrix bits r*STAGES+s, and ignore stages s < OUT_W-1. Modes 3 (wide permutation) and 4 (wide XOR) may use any stage.
- R9: cfgError is 1 in any of these cases: omMode = 3; omMode 1 without exactly one 1 in every row and every column; omMode 2 with an all-zero row; imMode > 4; imMode 1 with a row that does not have exactly one 1 inside stages OUT_W-1..STAGES-1, or with a column there that does not have exactly one 1; imMode 2 with a row that has a bit below OUT_W-1 or no bit at all; imMode 3 with a row that does not have exactly one 1, or with a stage used by two rows; imMode 4 with an all-zero row. A start request while cfgError is 1 is ignored.
- R10: An accepted start with runLength = L keeps busy high for exactly L clocks after the capture clock. Done then rises, and the signature holds until the next seed load or run. A start with runLength = 0 is ignored.
- R11: Configuration inputs are captured on the clock that accepts start. Changing them during a run has no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seedLoad | input | 1 | Load seedValue into the register when not busy |
| seedValue | input | STAGES | Initial register state |
| start | input | 1 | Request a test run and capture the configuration |
| runLength | input | CNT_W | Number of run clocks |
| serialIn | input | 1 | Serial bit XORed into stage 0 every run clock |
| tTypeMask | input | STAGES | 1 makes a stage toggle-type |
| wrapEn | input | 1 | Enable the wrap into stage 0 |
| topEn | input | 1 | Enable top parity feedback |
| botEn | input | 1 | Enable bottom feedback distribution |
| topTaps | input | STAGES | Top feedback tap vector |
| botTaps | input | STAGES | Bottom feedback stage selection |
| omMode | input | 2 | Output network mode |
| omMatrix | input | OUT_W*OUT_W | Output network matrix, row per stage |
| imMode | input | 3 | Input network mode |
| imMatrix | input | IN_W*STAGES | Input network matrix, row per circuit input |
| cutResp | input | OUT_W | Responses of the circuit under test |
| cutDrive | output | IN_W | Drives to the circuit under test |
| signature | output | STAGES | Register contents |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, signature final |
| cfgError | output | 1 | Present configuration is invalid |

## Verification
The register is driven by a small combinational stand-in for the circuit under test, which feeds cutDrive back into cutResp. Every run clock is compared against an independent next-state model. Directed runs first switch on one feature at a time: toggle stages, wrap, top taps, bottom taps, then top and bottom together. Comparing these runs shows which of the feedback terms is wrong. Each output and input matrix mode then gets its own run, which separates the response-folding network from the drive network. Seeded random valid configurations combine everything. A run with mid-run configuration and seed changes, a zero-length start, and invalid matrices show that input is ignored where it must be.

// File: rtl/loop_bist_pkg.sv
package loop_bist_pkg;

  typedef enum logic [1:0] {
    OM_DIRECT = 2'd0,
    OM_PERM   = 2'd1,
    OM_XOR    = 2'd2
  } omMode_e;

  typedef enum logic [2:0] {
    IM_DIRECT    = 3'd0,
    IM_PERM      = 3'd1,
    IM_XOR       = 3'd2,
    IM_PERM_WIDE = 3'd3,
    IM_XOR_WIDE  = 3'd4
  } imMode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } runState_e;

  typedef struct packed {
    logic loadSeed;
    logic capture;
    logic step;
  } ctrlStrobe_t;

endpackage

// File: rtl/loop_bist_cfgcheck.sv
module loop_bist_cfgcheck #(
  parameter int IN_W  = 4,
  parameter int OUT_W = 3,
  localparam int STAGES = IN_W + OUT_W - 1
) (
  input  logic [1:0]              omMode,
  input  logic [OUT_W*OUT_W-1:0]  omMatrix,
  input  logic [2:0]              imMode,
  input  logic [IN_W*STAGES-1:0]  imMatrix,
  output logic                    cfgError
);
  import loop_bist_pkg::*;

  localparam logic [STAGES-1:0] SHORT_COLS = {STAGES{1'b1}} << (OUT_W - 1);

  function automatic logic omBad(logic [1:0] mode, logic [OUT_W*OUT_W-1:0] mat);
    logic bad;
    int colCnt;
    bad = 1'b0;
    if (mode == 2'd3) bad = 1'b1;
    for (int i = 0; i < OUT_W; i++) begin
      if (mode == OM_PERM && $countones(mat[i*OUT_W +: OUT_W]) != 1) bad = 1'b1;
      if (mode == OM_XOR && mat[i*OUT_W +: OUT_W] == '0) bad = 1'b1;
    end
    if (mode == OM_PERM) begin
      for (int k = 0; k < OUT_W; k++) begin
        colCnt = 0;
        for (int i = 0; i < OUT_W; i++) colCnt = colCnt + (mat[i*OUT_W+k] ? 1 : 0);
        if (colCnt != 1) bad = 1'b1;
      end
    end
    return bad;
  endfunction

  function automatic logic imBad(logic [2:0] mode, logic [IN_W*STAGES-1:0] mat);
    logic bad;
    logic [STAGES-1:0] row;
    int colCnt;
    bad = (mode > 3'd4);
    for (int r = 0; r < IN_W; r++) begin
      row = mat[r*STAGES +: STAGES];
      case (mode)
        IM_PERM:      if ($countones(row) != 1 || (row & ~SHORT_COLS) != '0) bad = 1'b1;
        IM_XOR:       if ((row & SHORT_COLS) == '0 || (row & ~SHORT_COLS) != '0) bad = 1'b1;
        IM_PERM_WIDE: if ($countones(row) != 1) bad = 1'b1;
        IM_XOR_WIDE:  if (row == '0) bad = 1'b1;
        default: ;
      endcase
    end
    if (mode == IM_PERM || mode == IM_PERM_WIDE) begin
      for (int s = 0; s < STAGES; s++) begin
        colCnt = 0;
        for (int r = 0; r < IN_W; r++) colCnt = colCnt + (mat[r*STAGES+s] ? 1 : 0);
        if (mode == IM_PERM && SHORT_COLS[s] && colCnt != 1) bad = 1'b1;
        if (mode == IM_PERM_WIDE && colCnt > 1) bad = 1'b1;
      end
    end
    return bad;
  endfunction

  assign cfgError = omBad(omMode, omMatrix) | imBad(imMode, imMatrix);

endmodule

// File: rtl/loop_bist_ctrl.sv
module loop_bist_ctrl #(
  parameter int CNT_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic                          seedLoad,
  input  logic                          cfgError,
  input  logic [CNT_W-1:0]              runLength,
  output loop_bist_pkg::ctrlStrobe_t    strobe,
  output logic                          busy,
  output logic                          done
);
  import loop_bist_pkg::*;

  runState_e stQ;
  logic [CNT_W-1:0] cntQ;

  always_comb begin
    strobe.loadSeed = seedLoad && (stQ != ST_RUN);
    strobe.capture  = start && (stQ != ST_RUN) && !cfgError && (runLength != '0);
    strobe.step     = (stQ == ST_RUN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stQ  <= ST_IDLE;
      cntQ <= '0;
    end else begin
      case (stQ)
        ST_RUN: begin
          cntQ <= cntQ - 1'b1;
          if (cntQ == CNT_W'(1)) stQ <= ST_FIN;
        end
        default: begin
          if (strobe.capture) begin
            cntQ <= runLength;
            stQ  <= ST_RUN;
          end else if (strobe.loadSeed) begin
            stQ <= ST_IDLE;
          end
        end
      endcase
    end
  end

  assign busy = (stQ == ST_RUN);
  assign done = (stQ == ST_FIN);

endmodule

// File: rtl/loop_bist_path.sv
module loop_bist_path #(
  parameter int IN_W  = 4,
  parameter int OUT_W = 3,
  localparam int STAGES = IN_W + OUT_W - 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  loop_bist_pkg::ctrlStrobe_t  strobe,
  input  logic [STAGES-1:0]           seedValue,
  input  logic                        serialIn,
  input  logic [STAGES-1:0]           tTypeMask,
  input  logic                        wrapEn,
  input  logic                        topEn,
  input  logic                        botEn,
  input  logic [STAGES-1:0]           topTaps,
  input  logic [STAGES-1:0]           botTaps,
  input  logic [1:0]                  omMode,
  input  logic [OUT_W*OUT_W-1:0]      omMatrix,
  input  logic [2:0]                  imMode,
  input  logic [IN_W*STAGES-1:0]      imMatrix,
  input  logic [OUT_W-1:0]            cutResp,
  output logic [IN_W-1:0]             cutDrive,
  output logic [STAGES-1:0]           stateOut
);
  import loop_bist_pkg::*;

  localparam logic [STAGES-1:0] MSB_BIT    = STAGES'(1) << (STAGES - 1);
  localparam logic [STAGES-1:0] SHORT_COLS = {STAGES{1'b1}} << (OUT_W - 1);

  logic [STAGES-1:0]      stateQ, nextState;
  logic [STAGES-1:0]      tMaskQ, gQ, hQ;
  logic                   wrapQ, topQ, botQ;
  logic [1:0]             omModeQ;
  logic [OUT_W*OUT_W-1:0] omMatQ;
  logic [2:0]             imModeQ;
  logic [IN_W*STAGES-1:0] imMatQ;
  logic [OUT_W-1:0]       respMix;
  logic                   feedback, stage0Fb;

  // Response folding network: one parity per receiving stage
  always_comb begin
    for (int k = 0; k < OUT_W; k++) begin
      if (omModeQ == OM_DIRECT) respMix[k] = cutResp[k];
      else respMix[k] = ^(omMatQ[k*OUT_W +: OUT_W] & cutResp);
    end
  end

  // One shared feedback value serves stage 0 and every bottom tap
  always_comb begin
    feedback  = topQ ? ^(stateQ & (gQ | MSB_BIT)) : stateQ[STAGES-1];
    stage0Fb  = (wrapQ | topQ | botQ) & feedback;
    nextState = {stateQ[STAGES-2:0], 1'b0}
              ^ ((botQ & feedback) ? (hQ & ~STAGES'(1)) : '0)
              ^ STAGES'(stage0Fb ^ serialIn)
              ^ (tMaskQ & stateQ)
              ^ STAGES'(respMix);
  end

  // Drive network, one parity per circuit input
  for (genvar r = 0; r < IN_W; r++) begin : gDrive
    logic [STAGES-1:0] rowSel;
    assign rowSel = imMatQ[r*STAGES +: STAGES] & stateQ;
    always_comb begin
      case (imModeQ)
        IM_DIRECT:      cutDrive[r] = stateQ[OUT_W-1+r];
        IM_PERM, IM_XOR: cutDrive[r] = ^(rowSel & SHORT_COLS);
        default:        cutDrive[r] = ^rowSel;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ  <= '0;
      tMaskQ  <= '0;
      gQ      <= '0;
      hQ      <= '0;
      wrapQ   <= 1'b0;
      topQ    <= 1'b0;
      botQ    <= 1'b0;
      omModeQ <= '0;
      omMatQ  <= '0;
      imModeQ <= '0;
      imMatQ  <= '0;
    end else begin
      if (strobe.loadSeed)  stateQ <= seedValue;
      else if (strobe.step) stateQ <= nextState;
      if (strobe.capture) begin
        tMaskQ  <= tTypeMask;
        gQ      <= topTaps;
        hQ      <= botTaps;
        wrapQ   <= wrapEn;
        topQ    <= topEn;
        botQ    <= botEn;
        omModeQ <= omMode;
        omMatQ  <= omMatrix;
        imModeQ <= imMode;
        imMatQ  <= imMatrix;
      end
    end
  end

  assign stateOut = stateQ;

endmodule

// File: rtl/loop_bist_reg.sv
module loop_bist_reg #(
  parameter int IN_W  = 4,
  parameter int OUT_W = 3,
  parameter int CNT_W = 16,
  localparam int STAGES = IN_W + OUT_W - 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       seedLoad,
  input  logic [STAGES-1:0]          seedValue,
  input  logic                       start,
  input  logic [CNT_W-1:0]           runLength,
  input  logic                       serialIn,
  input  logic [STAGES-1:0]          tTypeMask,
  input  logic                       wrapEn,
  input  logic                       topEn,
  input  logic                       botEn,
  input  logic [STAGES-1:0]          topTaps,
  input  logic [STAGES-1:0]          botTaps,
  input  logic [1:0]                 omMode,
  input  logic [OUT_W*OUT_W-1:0]     omMatrix,
  input  logic [2:0]                 imMode,
  input  logic [IN_W*STAGES-1:0]     imMatrix,
  input  logic [OUT_W-1:0]           cutResp,
  output logic [IN_W-1:0]            cutDrive,
  output logic [STAGES-1:0]          signature,
  output logic                       busy,
  output logic                       done,
  output logic                       cfgError
);
  import loop_bist_pkg::*;

  ctrlStrobe_t strobe;

  loop_bist_cfgcheck #(.IN_W(IN_W), .OUT_W(OUT_W)) u_check (
    .omMode(omMode), .omMatrix(omMatrix), .imMode(imMode), .imMatrix(imMatrix),
    .cfgError(cfgError)
  );

  loop_bist_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .seedLoad(seedLoad),
    .cfgError(cfgError), .runLength(runLength),
    .strobe(strobe), .busy(busy), .done(done)
  );

  loop_bist_path #(.IN_W(IN_W), .OUT_W(OUT_W)) u_path (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .seedValue(seedValue),
    .serialIn(serialIn), .tTypeMask(tTypeMask), .wrapEn(wrapEn), .topEn(topEn),
    .botEn(botEn), .topTaps(topTaps), .botTaps(botTaps), .omMode(omMode),
    .omMatrix(omMatrix), .imMode(imMode), .imMatrix(imMatrix),
    .cutResp(cutResp), .cutDrive(cutDrive), .stateOut(signature)
  );

endmodule

// File: rtl/loop_bist_reg_sva.sv
module loop_bist_reg_sva #(
  parameter int IN_W  = 4,
  parameter int OUT_W = 3,
  parameter int CNT_W = 16,
  localparam int STAGES = IN_W + OUT_W - 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              seedLoad,
  input logic [STAGES-1:0] seedValue,
  input logic              start,
  input logic [CNT_W-1:0]  runLength,
  input logic              cfgError,
  input logic [STAGES-1:0] signature,
  input logic              busy,
  input logic              done
);

  // R1: reset clears the visible state
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (signature == '0 && !busy && !done));

  // R2: seed load while not busy
  a_r2_seed_load: assert property (@(posedge clk) disable iff (!rst_n)
    (seedLoad && !busy) |=> (signature == $past(seedValue)));

  // R10: signature holds outside a run unless reseeded
  a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !seedLoad) |=> $stable(signature));

  // R10: busy and done never together
  a_r10_excl_flags: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy, done}));

  // R10: done only follows a run
  a_r10_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

  // R9: invalid configuration refuses start
  a_r9_refuse_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && cfgError) |=> !busy);

  // R10: zero length start refused
  a_r10_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && runLength == '0) |=> !busy);

endmodule

bind loop_bist_reg loop_bist_reg_sva #(.IN_W(IN_W), .OUT_W(OUT_W), .CNT_W(CNT_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .seedLoad(seedLoad), .seedValue(seedValue),
  .start(start), .runLength(runLength), .cfgError(cfgError),
  .signature(signature), .busy(busy), .done(done)
);

// File: tb/loop_bist_reg_bench.sv
`timescale 1ns/1ps
module loop_bist_reg_bench;
  localparam int N  = 4;
  localparam int M  = 3;
  localparam int P  = N + M - 1;
  localparam int CW = 16;
  localparam logic [P-1:0] MSB   = P'(1) << (P - 1);
  localparam logic [P-1:0] SHORT = {P{1'b1}} << (M - 1);

  typedef struct packed {
    logic [P-1:0]   t;
    logic           wrap, top, bot;
    logic [P-1:0]   g, h;
    logic [1:0]     om;
    logic [M*M-1:0] omm;
    logic [2:0]     im;
    logic [N*P-1:0] imm;
  } cfg_s;

  logic clk = 1'b0, rst_n = 1'b0;
  logic seedLoad = 1'b0, start = 1'b0, serialIn = 1'b0;
  logic [P-1:0] seedValue = '0;
  logic [CW-1:0] runLength = '0;
  cfg_s cfg = '0, mCfg = '0;
  logic [P-1:0] mState = '0;
  logic [M-1:0] cutResp;
  logic [N-1:0] cutDrive;
  logic [P-1:0] signature;
  logic busy, done, cfgError;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  function automatic logic [M-1:0] cutFn(logic [N-1:0] d);
    logic [M-1:0] r;
    for (int k = 0; k < M; k++) r[k] = d[k % N] ^ (d[(k+1) % N] & d[(k+2) % N]);
    return r;
  endfunction

  assign cutResp = cutFn(cutDrive);

  loop_bist_reg #(.IN_W(N), .OUT_W(M), .CNT_W(CW)) u_loop_bist_reg (
    .clk(clk), .rst_n(rst_n), .seedLoad(seedLoad), .seedValue(seedValue),
    .start(start), .runLength(runLength), .serialIn(serialIn),
    .tTypeMask(cfg.t), .wrapEn(cfg.wrap), .topEn(cfg.top), .botEn(cfg.bot),
    .topTaps(cfg.g), .botTaps(cfg.h), .omMode(cfg.om), .omMatrix(cfg.omm),
    .imMode(cfg.im), .imMatrix(cfg.imm), .cutResp(cutResp), .cutDrive(cutDrive),
    .signature(signature), .busy(busy), .done(done), .cfgError(cfgError)
  );

  function automatic logic [N-1:0] refDrive(cfg_s c, logic [P-1:0] v);
    logic [N-1:0] d;
    for (int r = 0; r < N; r++) begin
      case (c.im)
        3'd0:       d[r] = v[M-1+r];
        3'd1, 3'd2: d[r] = ^(c.imm[r*P +: P] & v & SHORT);
        default:    d[r] = ^(c.imm[r*P +: P] & v);
      endcase
    end
    return d;
  endfunction

  function automatic logic [P-1:0] refNext(cfg_s c, logic [P-1:0] v, logic [M-1:0] r, logic s);
    logic [P-1:0] n, mixW;
    logic [M-1:0] mix;
    logic fb;
    fb = c.top ? ^(v & (c.g | MSB)) : v[P-1];
    for (int k = 0; k < M; k++) mix[k] = (c.om == 2'd0) ? r[k] : ^(c.omm[k*M +: M] & r);
    mixW = P'(mix);
    n[0] = ((c.wrap | c.top | c.bot) & fb) ^ s ^ (c.t[0] & v[0]) ^ mixW[0];
    for (int i = 1; i < P; i++)
      n[i] = v[i-1] ^ (c.bot & c.h[i] & fb) ^ (c.t[i] & v[i]) ^ mixW[i];
    return n;
  endfunction

  function automatic logic refErr(cfg_s c);
    logic bad;
    logic [P-1:0] row;
    int cnt;
    bad = (c.om == 2'd3) || (c.im > 3'd4);
    for (int i = 0; i < M; i++) begin
      if (c.om == 2'd1 && $countones(c.omm[i*M +: M]) != 1) bad = 1'b1;
      if (c.om == 2'd2 && c.omm[i*M +: M] == '0) bad = 1'b1;
      cnt = 0;
      for (int j = 0; j < M; j++) cnt = cnt + (c.omm[j*M+i] ? 1 : 0);
      if (c.om == 2'd1 && cnt != 1) bad = 1'b1;
    end
    for (int r = 0; r < N; r++) begin
      row = c.imm[r*P +: P];
      if (c.im == 3'd1 && ($countones(row) != 1 || (row & ~SHORT) != '0)) bad = 1'b1;
      if (c.im == 3'd2 && ((row & SHORT) == '0 || (row & ~SHORT) != '0)) bad = 1'b1;
      if (c.im == 3'd3 && $countones(row) != 1) bad = 1'b1;
      if (c.im == 3'd4 && row == '0) bad = 1'b1;
    end
    for (int s = 0; s < P; s++) begin
      cnt = 0;
      for (int r = 0; r < N; r++) cnt = cnt + (c.imm[r*P+s] ? 1 : 0);
      if (c.im == 3'd1 && SHORT[s] && cnt != 1) bad = 1'b1;
      if (c.im == 3'd3 && cnt > 1) bad = 1'b1;
    end
    return bad;
  endfunction

  function automatic cfg_s randCfg(logic [1:0] om, logic [2:0] im);
    cfg_s c;
    int rot;
    c = '0;
    c.t = P'($urandom); c.wrap = 1'($urandom); c.top = 1'($urandom); c.bot = 1'($urandom);
    c.g = P'($urandom); c.h = P'($urandom);
    c.om = om; c.im = im;
    rot = int'($urandom % 8);
    for (int i = 0; i < M; i++) begin
      if (om == 2'd1) c.omm[i*M + (i+rot) % M] = 1'b1;
      if (om == 2'd2) c.omm[i*M +: M] = M'($urandom) | M'(1 << (i % M));
    end
    for (int r = 0; r < N; r++) begin
      case (im)
        3'd1: c.imm[r*P + M-1 + (r+rot) % N] = 1'b1;
        3'd2: c.imm[r*P +: P] = (P'($urandom) & SHORT) | (P'(1) << (M-1+r));
        3'd3: c.imm[r*P + (r+rot) % P] = 1'b1;
        3'd4: c.imm[r*P +: P] = P'($urandom) | (P'(1) << r);
        default: c.imm[r*P +: P] = P'($urandom);
      endcase
    end
    return c;
  endfunction

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic loadSeed(input logic [P-1:0] s);
    @(negedge clk);
    seedLoad = 1'b1; seedValue = s;
    @(negedge clk);
    seedLoad = 1'b0;
    mState = s;
  endtask

  task automatic runTest(input string tag, input int len, input bit perturb);
    logic accept;
    logic [N-1:0] d;
    @(negedge clk);
    start = 1'b1; runLength = CW'(len);
    accept = !refErr(cfg) && (len != 0);
    @(negedge clk);
    start = 1'b0;
    if (accept) mCfg = cfg;
    check(busy == accept, tag, "busy after start", 64'(busy), 64'(accept));
    if (!accept) begin
      check(signature == mState, tag, "state kept on refused start", 64'(signature), 64'(mState));
      return;
    end
    for (int i = 0; i < len; i++) begin
      d = refDrive(mCfg, mState);
      check(signature == mState, tag, "run state", 64'(signature), 64'(mState));
      check(cutDrive == d, tag, "drive", 64'(cutDrive), 64'(d));
      seedLoad = 1'b0;
      if (perturb && i == 1) begin seedLoad = 1'b1; seedValue = ~mState; end
      if (perturb && i == len / 2) cfg = randCfg(2'($urandom % 3), 3'($urandom % 5));
      serialIn = 1'($urandom);
      mState = refNext(mCfg, mState, cutFn(d), serialIn);
      @(negedge clk);
    end
    seedLoad = 1'b0;
    check(done && !busy, tag, "done after run length", 64'({busy, done}), 64'h1);
    check(signature == mState, tag, "final signature", 64'(signature), 64'(mState));
    @(negedge clk);
    check(signature == mState && done, tag, "signature holds", 64'(signature), 64'(mState));
  endtask

  task automatic expectErr(input string what, input logic exp);
    #1;
    check(cfgError == exp && refErr(cfg) == exp, "R9", what, 64'(cfgError), 64'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    check(signature == '0 && !busy && !done, "R1", "reset state", 64'({signature, busy, done}), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(signature == '0 && !busy && !done, "R1", "after release", 64'({signature, busy, done}), 64'h0);

    loadSeed(6'b101101);
    check(signature == 6'b101101, "R2", "seed loaded", 64'(signature), 64'h2d);
    check(cutDrive == 4'b1011, "R8", "direct drive from upper stages", 64'(cutDrive), 64'hb);

    // R10 zero length
    runTest("R10", 0, 1'b0);

    // R9 invalid matrices
    cfg = '0; cfg.om = 2'd3; expectErr("om mode 3", 1'b1);
    cfg = '0; cfg.om = 2'd1; cfg.omm = 9'b001_001_010; expectErr("om perm column twice", 1'b1);
    cfg = '0; cfg.om = 2'd2; cfg.omm = 9'b011_000_100; expectErr("om xor empty row", 1'b1);
    cfg = '0; cfg.im = 3'd5; expectErr("im mode 5", 1'b1);
    cfg = randCfg(2'd0, 3'd2); cfg.imm[0] = 1'b1; expectErr("im xor short low stage", 1'b1);
    cfg = randCfg(2'd0, 3'd3); cfg.imm[P +: P] = cfg.imm[0 +: P]; expectErr("im wide perm stage reused", 1'b1);
    cfg = randCfg(2'd0, 3'd4); cfg.imm[2*P +: P] = '0; expectErr("im wide xor empty row", 1'b1);
    loadSeed(6'b010011);
    runTest("R9", 5, 1'b0);
    cfg = randCfg(2'd1, 3'd1); expectErr("valid perm config", 1'b0);

    // Directed single features
    cfg = '0; cfg.t = 6'b010010; loadSeed(6'b100111); runTest("R3", 10, 1'b0);
    cfg = '0; cfg.wrap = 1'b1; loadSeed(6'b100001); runTest("R4", 10, 1'b0);
    cfg = '0; cfg.top = 1'b1; cfg.g = 6'b001011; loadSeed(6'b110101); runTest("R5", 12, 1'b0);
    cfg = '0; cfg.bot = 1'b1; cfg.h = 6'b101010; loadSeed(6'b100010); runTest("R6", 12, 1'b0);
    cfg = '0; cfg.top = 1'b1; cfg.bot = 1'b1; cfg.g = 6'b000110; cfg.h = 6'b011100;
    loadSeed(6'b111000); runTest("R6", 12, 1'b0);
    for (int om = 1; om < 3; om++) begin
      cfg = randCfg(2'(om), 3'd0); loadSeed(P'($urandom)); runTest("R7", 10, 1'b0);
    end
    for (int im = 1; im < 5; im++) begin
      cfg = randCfg(2'd0, 3'(im)); loadSeed(P'($urandom)); runTest("R8", 10, 1'b0);
    end

    // Config and seed changes during a run
    cfg = randCfg(2'd2, 3'd4); loadSeed(6'b011011); runTest("R11", 14, 1'b1);
    cfg = randCfg(2'd1, 3'd2); loadSeed(6'b100100); runTest("R2", 8, 1'b1);

    // Random mix
    for (int n = 0; n < 40; n++) begin
      cfg = randCfg(2'($urandom % 3), 3'($urandom % 5));
      if ((n % 3) != 0) loadSeed(P'($urandom));
      runTest("R3", 1 + int'($urandom % 30), 1'b0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule